// File: doc/BRIEF.md
# Byte Table Lookup Permute

This block builds a 32-bit word by looking up each of its four bytes in a small byte table. The table is up to four 64-bit doublewords, supplied flat on one input bus. A 32-bit index word carries four 8-bit indices, one for each result byte. An index that falls inside the usable range picks one byte from the table. An index outside that range leaves the matching byte of an existing destination word in place. This lets software merge a lookup over several steps, one table slice per step.

The usable range is set at run time by a limit input and is also capped by the table size. A valid strobe qualifies each request. The result is registered and appears one cycle later with its own valid flag. When no request is presented, the result register holds its last value.

Top module: `byte_lut_permute`

## Requirements
- R1: While reset (rst_n low) is asserted, and in the first cycle after it is released, res_o is 0 and valid_o is 0.
- R2: valid_o in a cycle equals valid_i sampled at the previous rising clock edge.
- R3: The four result bytes are independent. Result byte k (bits 8k+7:8k) depends only on index bits 8k+7:8k, the table, the limit and destination bits 8k+7:8k.
- R4: An in-range index i selects table doubleword i[7:3] and byte i[2:0] inside it. Doubleword j sits at table_i bits 64j+63:64j, and byte n of a doubleword sits at its bits 8n+7:8n.
- R5: An index greater than limit_i, compared unsigned, yields the matching byte of dest_i.
- R6: An index equal to limit_i is in range and yields a table byte. A limit of 0 still allows index 0.
- R7: An index at or above 8*TBL_DW (32 by default) yields the destination byte, whatever the limit.
- R8: Indices of 128 and above are always out of range, even with a limit of 255.
- R9: When valid_i is low, res_o keeps its value on the next edge, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| table_i | input | 64*TBL_DW | Table contents, doubleword 0 in the low bits |
| idx_i | input | 32 | Four byte indices, lane k in bits 8k+7:8k |
| limit_i | input | 8 | Largest index treated as in range |
| dest_i | input | 32 | Existing destination word, kept in out-of-range lanes |
| res_o | output | 32 | Registered result word |
| valid_o | output | 1 | Result valid, one cycle after valid_i |

## Verification
The hardest case to reach is an index that passes the limit compare but lies beyond the table. This happens only when the limit input is set above the table size, which normal use never does. The stimulus sets limits of 200 and 255 together with indices between 32 and 255, so the table-size cap must act on its own. Other vectors mix in-range and out-of-range lanes in one word, with the limit placed exactly on one lane's index, so any leak between lanes or off-by-one error in the compare shows up as one wrong byte.

// File: rtl/blp_pkg.sv
package blp_pkg;

    // Bits and bytes in one table doubleword.
    localparam int unsigned DW_BITS  = 64;
    localparam int unsigned DW_BYTES = 8;
    // Index bits that pick a byte inside a doubleword.
    localparam int unsigned OFF_W    = 3;

    // Where a result byte is taken from.
    typedef enum logic {
        SRC_DEST  = 1'b0,
        SRC_TABLE = 1'b1
    } byte_src_e;

endpackage

// File: rtl/blp_range_chk.sv
module blp_range_chk
    import blp_pkg::*;
#(
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned TBL_BYTES = 32
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [IDX_W-1:0] limit_i,
    output byte_src_e        src_o
);

    localparam int unsigned CMP_W = IDX_W + 1;
    localparam logic [CMP_W-1:0] TBL_END = CMP_W'(TBL_BYTES);

    logic under_limit;
    logic inside_tbl;

    always_comb begin
        // Unsigned compare against the run-time limit.
        under_limit = (idx_i <= limit_i);
        // Cap by the number of bytes actually present.
        inside_tbl  = ({1'b0, idx_i} < TBL_END);
        src_o       = (under_limit && inside_tbl) ? SRC_TABLE : SRC_DEST;
    end

endmodule

// File: rtl/blp_byte_mux.sv
module blp_byte_mux
    import blp_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned TBL_DW = 4
) (
    input  logic [TBL_DW*DW_BITS-1:0] table_i,
    input  logic [BYTE_W-1:0]         idx_i,
    input  logic [BYTE_W-1:0]         dest_byte_i,
    input  byte_src_e                 src_i,
    output logic [BYTE_W-1:0]         byte_o
);

    localparam int unsigned DW_SEL_W = BYTE_W - OFF_W;

    logic [DW_SEL_W-1:0] dw_sel;
    logic [OFF_W-1:0]    off_sel;
    logic [BYTE_W-1:0]   tbl_byte;

    always_comb begin
        dw_sel   = idx_i[BYTE_W-1:OFF_W];
        off_sel  = idx_i[OFF_W-1:0];
        tbl_byte = '0;
        for (int j = 0; j < int'(TBL_DW); j++) begin
            for (int n = 0; n < int'(DW_BYTES); n++) begin
                if (dw_sel == DW_SEL_W'(j) && off_sel == OFF_W'(n)) begin
                    tbl_byte = table_i[j*DW_BITS + n*BYTE_W +: BYTE_W];
                end
            end
        end
        byte_o = (src_i == SRC_TABLE) ? tbl_byte : dest_byte_i;
    end

endmodule

// File: rtl/byte_lut_permute.sv
module byte_lut_permute
    import blp_pkg::*;
#(
    parameter int unsigned LANES  = 4,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned TBL_DW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_i,
    input  logic [TBL_DW*DW_BITS-1:0] table_i,
    input  logic [LANES*BYTE_W-1:0]   idx_i,
    input  logic [BYTE_W-1:0]         limit_i,
    input  logic [LANES*BYTE_W-1:0]   dest_i,
    output logic [LANES*BYTE_W-1:0]   res_o,
    output logic                      valid_o
);

    localparam int unsigned WORD_W    = LANES * BYTE_W;
    localparam int unsigned TBL_BYTES = TBL_DW * DW_BYTES;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [WORD_W-1:0] lane_res;

    for (genvar k = 0; k < int'(LANES); k++) begin : g_lane
        byte_src_e src;

        blp_range_chk #(
            .IDX_W    (BYTE_W),
            .TBL_BYTES(TBL_BYTES)
        ) u_rng (
            .idx_i  (idx_i[k*BYTE_W +: BYTE_W]),
            .limit_i(limit_i),
            .src_o  (src)
        );

        blp_byte_mux #(
            .BYTE_W(BYTE_W),
            .TBL_DW(TBL_DW)
        ) u_mux (
            .table_i    (table_i),
            .idx_i      (idx_i[k*BYTE_W +: BYTE_W]),
            .dest_byte_i(dest_i[k*BYTE_W +: BYTE_W]),
            .src_i      (src),
            .byte_o     (lane_res[k*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.res = lane_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o   = st_q.res;
    assign valid_o = st_q.vld;

endmodule

// File: rtl/blp_chk.sv
module blp_chk #(
    parameter int unsigned LANES     = 4,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned TBL_BYTES = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    valid_i,
    input logic [LANES*BYTE_W-1:0] idx_i,
    input logic [BYTE_W-1:0]       limit_i,
    input logic [LANES*BYTE_W-1:0] dest_i,
    input logic [LANES*BYTE_W-1:0] res_o,
    input logic                    valid_o
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    // R9
    hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(res_o));

    always @(posedge clk) begin
        // R1
        if (!rst_n) begin
            reset_zero_chk: assert (res_o == '0 && !valid_o);
        end
    end

    for (genvar k = 0; k < int'(LANES); k++) begin : g_lane_chk
        // R5
        over_limit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && idx_i[k*BYTE_W +: BYTE_W] > limit_i)
            |=> res_o[k*BYTE_W +: BYTE_W] == $past(dest_i[k*BYTE_W +: BYTE_W]));

        // R7
        past_table_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && int'(idx_i[k*BYTE_W +: BYTE_W]) >= int'(TBL_BYTES))
            |=> res_o[k*BYTE_W +: BYTE_W] == $past(dest_i[k*BYTE_W +: BYTE_W]));
    end

endmodule

bind byte_lut_permute blp_chk #(
    .LANES    (LANES),
    .BYTE_W   (BYTE_W),
    .TBL_BYTES(TBL_BYTES)
) u_blp_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .valid_i(valid_i),
    .idx_i  (idx_i),
    .limit_i(limit_i),
    .dest_i (dest_i),
    .res_o  (res_o),
    .valid_o(valid_o)
);

// File: tb/byte_lut_permute_test.sv
module byte_lut_permute_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         valid_i;
    logic [255:0] table_i;
    logic [31:0]  idx_i;
    logic [7:0]   limit_i;
    logic [31:0]  dest_i;
    logic [31:0]  res_o;
    logic         valid_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    byte_lut_permute uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(valid_i),
        .table_i(table_i),
        .idx_i  (idx_i),
        .limit_i(limit_i),
        .dest_i (dest_i),
        .res_o  (res_o),
        .valid_o(valid_o)
    );

    // Table byte at flat position p (doubleword p/8, byte p%8) is 0x40 + p.
    typedef struct packed {
        logic [31:0] idx;
        logic [7:0]  lim;
        logic [31:0] dst;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h03020100, 8'd31,  32'hFFFFFFFF, 32'h43424140}, // R3 R4 plain lanes
        '{32'h1F100807, 8'd31,  32'hFFFFFFFF, 32'h5F504847}, // R4 doubleword edges
        '{32'h08070605, 8'd7,   32'hAABBCCDD, 32'hAA474645}, // R5 R6 limit 7
        '{32'h80FF2010, 8'd31,  32'h11223344, 32'h11223350}, // R5 R8 high indices
        '{32'h21201F00, 8'd255, 32'h99887766, 32'h99885F40}, // R7 limit past table
        '{32'h00010000, 8'd0,   32'h12345678, 32'h40344040}, // R6 limit 0
        '{32'h81C89000, 8'd200, 32'h01020304, 32'h01020340}, // R7 R8 limit 200
        '{32'h0F0E0D0C, 8'd14,  32'hCAFEBABE, 32'hCA4E4D4C}  // R3 R6 mixed lanes
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] idx, input logic [7:0] lim, input logic [31:0] dst);
        @(negedge clk);
        idx_i   = idx;
        limit_i = lim;
        dest_i  = dst;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        rst_n   = 1'b0;
        valid_i = 1'b0;
        idx_i   = '0;
        limit_i = '0;
        dest_i  = '0;
        for (int p = 0; p < 32; p++) table_i[p*8 +: 8] = 8'h40 + 8'(p);

        repeat (3) @(negedge clk);
        check32("R1 reset res", res_o, 32'h0);
        check32("R1 reset valid", {31'b0, valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1 after release res", res_o, 32'h0);
        check32("R1 after release valid", {31'b0, valid_o}, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            apply(VECS[v].idx, VECS[v].lim, VECS[v].dst);
            check32($sformatf("R3 R4 R5 R6 R7 R8 vector %0d", v), res_o, VECS[v].exp);
            check32($sformatf("R2 valid vector %0d", v), {31'b0, valid_o}, 32'h1);
        end

        // R9: inputs change with no strobe, result must hold.
        held    = res_o;
        idx_i   = 32'h00000000;
        limit_i = 8'd31;
        dest_i  = 32'h00000000;
        @(negedge clk);
        check32("R9 hold without strobe", res_o, held);
        check32("R2 valid low", {31'b0, valid_o}, 32'h0);
        @(negedge clk);
        check32("R9 hold second cycle", res_o, held);

        // R5: every index above the limit keeps the destination word.
        apply(32'h1E1D1C1B, 8'd10, 32'h5A5A5A5A);
        check32("R5 all above limit", res_o, 32'h5A5A5A5A);

        // R8: limit 255, all indices 128 and above.
        apply(32'hFF80C0A0, 8'd255, 32'h0BADF00D);
        check32("R8 high indices kept", res_o, 32'h0BADF00D);

        // R4: one lane reads the last byte of the last doubleword.
        apply(32'h1F1F1F1F, 8'd31, 32'h0);
        check32("R4 top byte all lanes", res_o, 32'h5F5F5F5F);

        // R3: change only lane 2 index, other lanes unaffected.
        apply(32'h03180100, 8'd31, 32'h0);
        check32("R3 lane independence", res_o, 32'h43584140);

        // R1: asynchronous reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check32("R1 mid reset res", res_o, 32'h0);
        check32("R1 mid reset valid", {31'b0, valid_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule